// File: doc/BRIEF.md
# Register-Programmable Sum-of-Products Array

This block is a small logic array whose two planes are both set at run time. The first plane forms product terms. Each term stores one two-bit literal code per input. The code says whether the input must be 1, must be 0, is ignored, or whether the whole term is switched off. The second plane forms the outputs. Each output stores a bit mask over the product terms and drives the OR of the terms it selects. A term can feed any number of outputs.

Configuration words enter through a clocked write port with an address and a data word. Addresses below the term count pick a product-term row. The next block of addresses picks an output mask. Any higher address is ignored. Evaluation is purely combinational from the inputs and the stored planes, so a new configuration is seen at the outputs right after the clock edge that stores it. Reset switches every term off, so all outputs read 0 until the array is programmed.

Top module: `pla_fabric`

## Requirements
- R1: While reset is high, and in every cycle after it until the first configuration write, all bits of `pla_out` are 0 for every input pattern. Reset stores the off code 2'b11 in every literal and clears every output mask.
- R2: Literal code 2'b10 makes a term need its input at 1. Literal code 2'b01 makes a term need its input at 0. The literal for input i sits at bits [2i+1:2i] of a term-row word.
- R3: Literal code 2'b00 drops the input from the term. A term whose literals are all 2'b00 is always active.
- R4: Literal code 2'b11 in any position forces its term to 0 for every input pattern.
- R5: A write with `cfg_addr` = t, where t is below N_TERM, replaces the whole literal row of product term t.
- R6: A write with `cfg_addr` = N_TERM + j replaces the mask of output j. Bit t of the mask selects term t, and data bits at or above N_TERM are ignored. Output j is the OR of its selected terms and is 0 when none of them is active.
- R7: One product term may be selected by several outputs at once, and each of those outputs follows it.
- R8: A configuration write applies at the clock edge where `cfg_we` is sampled high. From that edge on, the outputs reflect the new configuration with no further clock.
- R9: A write to an address at or above N_TERM + N_OUT changes no term row and no output mask.
- R10: `pla_out` follows changes on `pla_in` combinationally, with no clock edge between the two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration store |
| rst | input | 1 | Synchronous active-high reset; switches all terms off |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | $clog2(N_TERM+N_OUT) | Row select: term rows first, then output masks |
| cfg_data | input | max(2*N_IN, N_TERM) | Literal row or output mask to store |
| pla_in | input | N_IN | Logic inputs to the array |
| pla_out | output | N_OUT | Sum-of-products outputs |

## Verification
The bench builds the array with its defaults: three inputs, five terms and four outputs. With these values each sweep can drive all eight input patterns, and the four-bit address reaches the nine real rows as well as seven out-of-range addresses. The data word is six bits wide while a mask is five, so one mask bit lies beyond the term count and can be shown to be ignored. A behavioural model of the planes is compared with the outputs after every write and at every input step. The array is reset again part way through the run to show that the off state returns.

// File: rtl/pla_pkg.sv
package pla_pkg;

   // Per-input literal code of a product term
   typedef enum logic [1:0] {
      LIT_ANY  = 2'b00,
      LIT_LOW  = 2'b01,
      LIT_HIGH = 2'b10,
      LIT_OFF  = 2'b11
   } lit_e;

   // Whether one literal lets its term stay active for input value v
   function automatic logic lit_pass(input lit_e code, input logic v);
      logic ok;
      case (code)
         LIT_ANY:  ok = 1'b1;
         LIT_LOW:  ok = ~v;
         LIT_HIGH: ok = v;
         default:  ok = 1'b0;
      endcase
      return ok;
   endfunction

endpackage

// File: rtl/pla_cfg_decode.sv
module pla_cfg_decode #(
   parameter int N_TERM = 5,
   parameter int N_OUT  = 4,
   parameter int AW     = 4
) (
   input  logic              we,
   input  logic [AW-1:0]     addr,
   output logic [N_TERM-1:0] term_sel,
   output logic [N_OUT-1:0]  mask_sel
);

   localparam int N_ROWS = N_TERM + N_OUT;

   if (N_ROWS > (1 << AW)) begin : g_aw_err
      $error("pla_cfg_decode: AW too narrow for N_TERM + N_OUT rows");
   end

   for (genvar t = 0; t < N_TERM; t++) begin : g_term_sel
      assign term_sel[t] = we && (addr == AW'(t));
   end

   for (genvar j = 0; j < N_OUT; j++) begin : g_mask_sel
      assign mask_sel[j] = we && (addr == AW'(N_TERM + j));
   end

endmodule

// File: rtl/pla_and_plane.sv
module pla_and_plane
   import pla_pkg::*;
#(
   parameter int N_IN   = 3,
   parameter int N_TERM = 5
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [N_TERM-1:0] term_sel,
   input  logic [2*N_IN-1:0] wdata,
   input  logic [N_IN-1:0]   in_vec,
   output logic [N_TERM-1:0] term_act
);

   logic [N_TERM-1:0][N_IN-1:0][1:0] row_q;
   logic [N_TERM-1:0][N_IN-1:0]      lit_ok;
   logic [N_TERM-1:0]                has_off;

   for (genvar t = 0; t < N_TERM; t++) begin : g_row
      always_ff @(posedge clk) begin
         if (rst) begin
            row_q[t] <= '1;
         end else if (term_sel[t]) begin
            row_q[t] <= wdata;
         end
      end

      for (genvar i = 0; i < N_IN; i++) begin : g_lit
         assign lit_ok[t][i] = lit_pass(lit_e'(row_q[t][i]), in_vec[i]);
      end

      assign term_act[t] = &lit_ok[t];

      always_comb begin
         has_off[t] = 1'b0;
         for (int i = 0; i < N_IN; i++) begin
            if (row_q[t][i] == 2'b11) has_off[t] = 1'b1;
         end
      end

      // R4
      off_term_chk: assert property (@(posedge clk) disable iff (rst)
         has_off[t] |-> !term_act[t]);
   end

   // R9
   row_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (term_sel == '0) |=> $stable(row_q));

endmodule

// File: rtl/pla_or_plane.sv
module pla_or_plane #(
   parameter int N_TERM = 5,
   parameter int N_OUT  = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [N_OUT-1:0]  mask_sel,
   input  logic [N_TERM-1:0] wdata,
   input  logic [N_TERM-1:0] term_act,
   output logic [N_OUT-1:0]  sum_out
);

   logic [N_OUT-1:0][N_TERM-1:0] mask_q;

   for (genvar j = 0; j < N_OUT; j++) begin : g_out
      always_ff @(posedge clk) begin
         if (rst) begin
            mask_q[j] <= '0;
         end else if (mask_sel[j]) begin
            mask_q[j] <= wdata;
         end
      end

      assign sum_out[j] = |(mask_q[j] & term_act);
   end

   // R6
   idle_terms_chk: assert property (@(posedge clk) disable iff (rst)
      (term_act == '0) |-> (sum_out == '0));

   // R9
   mask_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (mask_sel == '0) |=> $stable(mask_q));

   // R1
   reset_mask_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(rst) |-> (mask_q == '0));

endmodule

// File: rtl/pla_fabric.sv
module pla_fabric #(
   parameter int N_IN   = 3,
   parameter int N_TERM = 5,
   parameter int N_OUT  = 4,
   localparam int N_ROWS = N_TERM + N_OUT,
   localparam int AW     = (N_ROWS > 1) ? $clog2(N_ROWS) : 1,
   localparam int CW     = (2 * N_IN > N_TERM) ? 2 * N_IN : N_TERM
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          cfg_we,
   input  logic [AW-1:0] cfg_addr,
   input  logic [CW-1:0] cfg_data,
   input  logic [N_IN-1:0]  pla_in,
   output logic [N_OUT-1:0] pla_out
);

   if (N_IN < 1 || N_TERM < 1 || N_OUT < 1) begin : g_size_err
      $error("pla_fabric: every dimension must be at least 1");
   end

   logic [N_TERM-1:0] term_sel;
   logic [N_OUT-1:0]  mask_sel;
   logic [N_TERM-1:0] term_act;

   pla_cfg_decode #(
      .N_TERM (N_TERM),
      .N_OUT  (N_OUT),
      .AW     (AW)
   ) u_dec (
      .we       (cfg_we),
      .addr     (cfg_addr),
      .term_sel (term_sel),
      .mask_sel (mask_sel)
   );

   pla_and_plane #(
      .N_IN   (N_IN),
      .N_TERM (N_TERM)
   ) u_and (
      .clk      (clk),
      .rst      (rst),
      .term_sel (term_sel),
      .wdata    (cfg_data[2*N_IN-1:0]),
      .in_vec   (pla_in),
      .term_act (term_act)
   );

   pla_or_plane #(
      .N_TERM (N_TERM),
      .N_OUT  (N_OUT)
   ) u_or (
      .clk      (clk),
      .rst      (rst),
      .mask_sel (mask_sel),
      .wdata    (cfg_data[N_TERM-1:0]),
      .term_act (term_act),
      .sum_out  (pla_out)
   );

   // R5
   sel_onehot_chk: assert property (@(posedge clk) disable iff (rst)
      $onehot0({mask_sel, term_sel}));

   // R9
   oob_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      (cfg_we && (int'(cfg_addr) >= N_ROWS)) |-> ({mask_sel, term_sel} == '0));

endmodule

// File: tb/sim_pla_fabric.sv
module sim_pla_fabric;

   localparam int NI = 3;
   localparam int NT = 5;
   localparam int NO = 4;
   localparam int AW = 4;
   localparam int CW = 6;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          cfg_we = 1'b0;
   logic [AW-1:0] cfg_addr = '0;
   logic [CW-1:0] cfg_data = '0;
   logic [NI-1:0] pla_in = '0;
   logic [NO-1:0] pla_out;

   int n_run = 0;
   int n_fail = 0;

   // model state
   logic [CW-1:0] m_row [NT];
   logic [NT-1:0] m_mask [NO];

   always #4 clk = ~clk;

   pla_fabric #(.N_IN(NI), .N_TERM(NT), .N_OUT(NO)) u0 (
      .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_data(cfg_data), .pla_in(pla_in), .pla_out(pla_out)
   );

   task automatic model_reset();
      for (int t = 0; t < NT; t++) m_row[t] = '1;
      for (int j = 0; j < NO; j++) m_mask[j] = '0;
   endtask

   function automatic logic [NO-1:0] ref_out(input logic [NI-1:0] v);
      logic [NO-1:0] r = '0;
      for (int t = 0; t < NT; t++) begin
         bit on = 1;
         for (int i = 0; i < NI; i++) begin
            int code = int'(m_row[t][2*i +: 2]);
            if (code == 3) on = 0;
            else if (code == 2 && !v[i]) on = 0;
            else if (code == 1 && v[i]) on = 0;
         end
         for (int j = 0; j < NO; j++)
            if (on && m_mask[j][t]) r[j] = 1'b1;
      end
      return r;
   endfunction

   task automatic check(input string tag, input logic [NO-1:0] exp);
      n_run++;
      if (pla_out !== exp) begin
         n_fail++;
         $display("FAIL %s in=%b actual=%b expected=%b", tag, pla_in, pla_out, exp);
      end
   endtask

   // drive every input pattern, one per clock, compare at the falling edge
   task automatic sweep(input string tag, input bit expect_zero);
      for (int v = 0; v < (1 << NI); v++) begin
         @(posedge clk);
         #1 pla_in = NI'(v);
         @(negedge clk);
         check(tag, expect_zero ? '0 : ref_out(pla_in));
      end
   endtask

   task automatic cfg_write(input int a, input logic [CW-1:0] d);
      @(posedge clk);
      #1;
      cfg_we = 1'b1;
      cfg_addr = AW'(a);
      cfg_data = d;
      @(posedge clk);
      if (a < NT) m_row[a] = d;
      else if (a < NT + NO) m_mask[a - NT] = d[NT-1:0];
      #1 cfg_we = 1'b0;
      @(negedge clk);
      // R8: new configuration visible in the cycle after the write edge
      check("R8", ref_out(pla_in));
   endtask

   initial begin
      model_reset();
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R1 during reset", '0);
      #1 rst = 1'b0;
      sweep("R1 after reset", 1'b1);

      // all-absent term 0, no mask yet: output still 0
      cfg_write(0, 6'b00_00_00);
      sweep("R6 no term selected", 1'b1);
      cfg_write(NT + 0, 5'b00001);
      sweep("R3 all-absent term", 1'b0);

      // term1: in0 high, in1 absent, in2 low
      cfg_write(1, 6'b01_00_10);
      cfg_write(NT + 1, 6'b100010);   // bit 5 beyond term count
      sweep("R2 true and complement literals", 1'b0);
      sweep("R6 high mask bit ignored", 1'b0);

      // term2 has an off literal on in0
      cfg_write(2, 6'b00_10_11);
      cfg_write(NT + 2, 5'b00100);
      sweep("R4 off literal", 1'b0);

      // term3: in1 low, in2 high; output 3 shares term1
      cfg_write(3, 6'b10_01_00);
      cfg_write(NT + 3, 5'b01010);
      sweep("R7 shared term", 1'b0);

      // replace a term row and watch both users follow
      cfg_write(1, 6'b00_10_00);
      sweep("R5 row rewrite", 1'b0);

      // out-of-range writes
      for (int a = NT + NO; a < (1 << AW); a++) cfg_write(a, '1);
      sweep("R9 out-of-range write", 1'b0);

      // combinational input path, no clock edge between
      @(negedge clk);
      #1 pla_in = 3'b101;
      #1 check("R10 input change", ref_out(pla_in));
      #1 pla_in = 3'b010;
      #1 check("R10 input change", ref_out(pla_in));

      // reset again
      @(posedge clk);
      #1 rst = 1'b1;
      @(posedge clk);
      model_reset();
      #1 rst = 1'b0;
      sweep("R1 re-reset", 1'b1);

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule